// File: doc/BRIEF.md
# Floating-point and vector context image writer

This block stores a snapshot of the floating-point stack, the SIMD control and status registers and the vector register file into a 512-byte memory image. A start pulse begins the save. The block first checks the base address. If the address is aligned, the block issues one 16-byte line per accepted handshake through a plain write port, in ascending order.

The register values and the mode flags arrive as parallel inputs, and the block only reads them. It compresses the 16-bit two-bit-per-register tag word into one byte while it packs the first line. The mode flags choose how wide the instruction and data pointers are stored and how many vector registers are saved. In 16-bit addressing mode the pointers are cut to 16 bits. The last 48 bytes of the image belong to software, and the block never writes them.

Top module: `fpctx_image_writer`

## Requirements
- R1: If `start` is seen while idle and `base_addr[3:0]` is not zero, `fault` goes high for exactly the next cycle and no write is issued.
- R2: For an aligned start, the block issues exactly 29 lines at `base + 16*n` for n = 0..28, in ascending order. It begins in the cycle after the start and holds `wr_valid` until the last line is accepted. Nothing is written at base+464 or above.
- R3: While `wr_valid` is high and `wr_ready` is low, the address and data of the pending line stay unchanged.
- R4: With `ptr64_fmt`=0, line 0 holds the following fields:
  - `ctrl_word` in bits 15:0
  - `stat_word` in bits 31:16
  - the abridged tag in bits 39:32
  - the opcode in bits 63:48
  - the 32-bit instruction offset in bits 95:64
  - `ip_sel` in bits 111:96

  Line 1 holds the following fields:
  - the 32-bit data offset in bits 31:0
  - `dp_sel` in bits 47:32
  - `simd_csr` in bits 95:64
  - `simd_csr_mask` in bits 127:96

  All other bits of both lines are zero.
- R5: With `ptr64_fmt`=1, line 0 holds the 64-bit instruction pointer in bits 127:64, and line 1 holds the 64-bit data pointer in bits 63:0. Neither line carries a selector. The remaining fields stay where R4 places them.
- R6: Bit i of the abridged tag is 0 when `tag_word[2i+1:2i]` is 2'b11 and 1 otherwise, for physical registers i = 0..7.
- R7: Opcode bits 15:11 are always written as zero. When `addr16_mode`=1, every pointer bit above bit 15 is written as zero.
- R8: Lines 2..9 carry stack register k = n-2 (slice `stk_regs[80k+79:80k]`) in bits 79:0, with bits 127:80 zero.
- R9: Lines 10..17 carry vector registers 0..7 (slice `vec_regs[128j+127:128j]`). Lines 18..25 carry vector registers 8..15 when `long_mode`=1 and zero otherwise. Lines 26..28 are zero.
- R10: `done` pulses for one cycle, one cycle after the last line is accepted. A start in that cycle is accepted. A start while lines are pending is ignored.
- R11: `wr_be` is all ones on every issued line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a save (only seen while idle) |
| base_addr | input | ADDR_W | Byte address of the image |
| long_mode | input | 1 | Save vector registers 8..15 |
| ptr64_fmt | input | 1 | Store 64-bit pointers without selectors |
| addr16_mode | input | 1 | Keep only the low 16 pointer bits |
| ctrl_word | input | 16 | FP control word |
| stat_word | input | 16 | FP status word |
| tag_word | input | 16 | Full tag word, two bits per physical register |
| last_opc | input | 16 | Last FP opcode |
| ip_off | input | 64 | Instruction pointer offset |
| ip_sel | input | 16 | Instruction pointer selector |
| dp_off | input | 64 | Data pointer offset |
| dp_sel | input | 16 | Data pointer selector |
| simd_csr | input | 32 | SIMD control/status register |
| simd_csr_mask | input | 32 | Writable-bit mask of that register |
| stk_regs | input | 640 | Eight 80-bit stack registers |
| vec_regs | input | 2048 | Sixteen 128-bit vector registers |
| wr_valid | output | 1 | Line write request |
| wr_ready | input | 1 | Line accepted when high with wr_valid |
| wr_addr | output | ADDR_W | Line byte address |
| wr_data | output | 128 | Line data |
| wr_be | output | 16 | Byte enables |
| done | output | 1 | Save finished pulse |
| fault | output | 1 | Misaligned base pulse |

## Verification
Two events can fall in the same cycle: the `done` pulse that ends one image and the `start` that opens the next. The bench runs its images back to back and raises `start` in the very cycle it sees `done`. It then requires the first line of the new image, at the new base, on the next cycle. In a separate run, `start` is pulsed with a misaligned base while lines are still pending. That run must then show an unchanged address sequence and no `fault`.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;
    localparam int LINE_W     = 128;
    localparam int LINE_BYTES = LINE_W / 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int NUM_STK    = 8;
    localparam int STK_W      = 80;
    localparam int NUM_VEC    = 16;
    localparam int VEC_W      = 128;
    localparam int PTR_W      = 64;
    localparam int TAG_W      = 2 * NUM_STK;
    localparam int TAIL_BYTE  = 464;

    localparam int LN_HDR0    = 0;
    localparam int LN_HDR1    = 1;
    localparam int LN_STK0    = 2;
    localparam int LN_VEC0    = LN_STK0 + NUM_STK;
    localparam int LN_VEC_HI  = LN_VEC0 + NUM_VEC / 2;
    localparam int LN_VEC_END = LN_VEC0 + NUM_VEC;
    localparam int LN_LAST    = TAIL_BYTE / LINE_BYTES - 1;
    localparam int IDX_W      = $clog2(LN_LAST + 1);
    localparam int STK_SEL_W  = $clog2(NUM_STK);
    localparam int VEC_SEL_W  = $clog2(NUM_VEC);

    function automatic logic [PTR_W-1:0] trim_ptr(input logic [PTR_W-1:0] p,
                                                  input logic short_addr);
        trim_ptr = short_addr ? {{(PTR_W-16){1'b0}}, p[15:0]} : p;
    endfunction
endpackage

// File: rtl/fpctx_tag_abridge.sv
module fpctx_tag_abridge
    import fpctx_pkg::*;
(
    input  logic [TAG_W-1:0]   tag_word,
    output logic [NUM_STK-1:0] tag_byte
);
    for (genvar g = 0; g < NUM_STK; g++) begin : g_reg
        assign tag_byte[g] = ~(tag_word[2*g+1] & tag_word[2*g]);
    end
endmodule

// File: rtl/fpctx_line_pack.sv
module fpctx_line_pack
    import fpctx_pkg::*;
(
    input  logic [IDX_W-1:0]         idx,
    input  logic                     long_mode,
    input  logic                     ptr64_fmt,
    input  logic                     addr16_mode,
    input  logic [15:0]              ctrl_word,
    input  logic [15:0]              stat_word,
    input  logic [NUM_STK-1:0]       tag_byte,
    input  logic [15:0]              last_opc,
    input  logic [PTR_W-1:0]         ip_off,
    input  logic [15:0]              ip_sel,
    input  logic [PTR_W-1:0]         dp_off,
    input  logic [15:0]              dp_sel,
    input  logic [31:0]              simd_csr,
    input  logic [31:0]              simd_csr_mask,
    input  logic [NUM_STK*STK_W-1:0] stk_regs,
    input  logic [NUM_VEC*VEC_W-1:0] vec_regs,
    output logic [LINE_W-1:0]        line
);
    logic [STK_W-1:0]     stk_arr [NUM_STK];
    logic [VEC_W-1:0]     vec_arr [NUM_VEC];
    logic [STK_SEL_W-1:0] stk_sel;
    logic [VEC_SEL_W-1:0] vec_sel;
    logic [PTR_W-1:0]     ip_v;
    logic [PTR_W-1:0]     dp_v;
    logic [15:0]          opc_v;
    logic                 in_stk;
    logic                 in_vec_lo;
    logic                 in_vec_hi;

    for (genvar g = 0; g < NUM_STK; g++) begin : g_stk
        assign stk_arr[g] = stk_regs[g*STK_W +: STK_W];
    end
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        assign vec_arr[g] = vec_regs[g*VEC_W +: VEC_W];
    end

    assign stk_sel   = STK_SEL_W'(idx - IDX_W'(LN_STK0));
    assign vec_sel   = VEC_SEL_W'(idx - IDX_W'(LN_VEC0));
    assign in_stk    = (idx >= IDX_W'(LN_STK0))   && (idx < IDX_W'(LN_VEC0));
    assign in_vec_lo = (idx >= IDX_W'(LN_VEC0))   && (idx < IDX_W'(LN_VEC_HI));
    assign in_vec_hi = (idx >= IDX_W'(LN_VEC_HI)) && (idx < IDX_W'(LN_VEC_END));

    always_comb begin
        ip_v  = trim_ptr(ip_off, addr16_mode);
        dp_v  = trim_ptr(dp_off, addr16_mode);
        opc_v = {5'b0, last_opc[10:0]};
        line  = '0;
        if (idx == IDX_W'(LN_HDR0)) begin
            line[15:0]  = ctrl_word;
            line[31:16] = stat_word;
            line[39:32] = tag_byte;
            line[63:48] = opc_v;
            if (ptr64_fmt) begin
                line[127:64] = ip_v;
            end else begin
                line[95:64]  = ip_v[31:0];
                line[111:96] = ip_sel;
            end
        end else if (idx == IDX_W'(LN_HDR1)) begin
            line[95:64]  = simd_csr;
            line[127:96] = simd_csr_mask;
            if (ptr64_fmt) begin
                line[63:0] = dp_v;
            end else begin
                line[31:0]  = dp_v[31:0];
                line[47:32] = dp_sel;
            end
        end else if (in_stk) begin
            line[STK_W-1:0] = stk_arr[stk_sel];
        end else if (in_vec_lo || (in_vec_hi && long_mode)) begin
            line = vec_arr[vec_sel];
        end
    end
endmodule

// File: rtl/fpctx_seq.sv
module fpctx_seq
    import fpctx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [IDX_W-1:0]  line_idx,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              done,
    output logic              fault
);
    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic              done;
        logic              fault;
    } seq_t;

    seq_t st_d;
    seq_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.fault = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                if (base_addr[OFF_W-1:0] != '0) begin
                    st_d.fault = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.idx  = '0;
                    st_d.base = base_addr;
                end
            end
        end else if (wr_ready) begin
            if (st_q.idx == IDX_W'(LN_LAST)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.busy;
    assign line_idx = st_q.idx;
    assign wr_addr  = st_q.base + (ADDR_W'(st_q.idx) << OFF_W);
    assign done     = st_q.done;
    assign fault    = st_q.fault;
endmodule

// File: rtl/fpctx_image_writer.sv
module fpctx_image_writer
    import fpctx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic                     long_mode,
    input  logic                     ptr64_fmt,
    input  logic                     addr16_mode,
    input  logic [15:0]              ctrl_word,
    input  logic [15:0]              stat_word,
    input  logic [TAG_W-1:0]         tag_word,
    input  logic [15:0]              last_opc,
    input  logic [PTR_W-1:0]         ip_off,
    input  logic [15:0]              ip_sel,
    input  logic [PTR_W-1:0]         dp_off,
    input  logic [15:0]              dp_sel,
    input  logic [31:0]              simd_csr,
    input  logic [31:0]              simd_csr_mask,
    input  logic [NUM_STK*STK_W-1:0] stk_regs,
    input  logic [NUM_VEC*VEC_W-1:0] vec_regs,
    output logic                     wr_valid,
    input  logic                     wr_ready,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [LINE_W-1:0]        wr_data,
    output logic [LINE_BYTES-1:0]    wr_be,
    output logic                     done,
    output logic                     fault
);
    logic [IDX_W-1:0]   line_idx;
    logic [NUM_STK-1:0] tag_byte;

    fpctx_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .base_addr(base_addr),
        .wr_ready (wr_ready),
        .wr_valid (wr_valid),
        .line_idx (line_idx),
        .wr_addr  (wr_addr),
        .done     (done),
        .fault    (fault)
    );

    fpctx_tag_abridge u_tag (
        .tag_word(tag_word),
        .tag_byte(tag_byte)
    );

    fpctx_line_pack u_pack (
        .idx          (line_idx),
        .long_mode    (long_mode),
        .ptr64_fmt    (ptr64_fmt),
        .addr16_mode  (addr16_mode),
        .ctrl_word    (ctrl_word),
        .stat_word    (stat_word),
        .tag_byte     (tag_byte),
        .last_opc     (last_opc),
        .ip_off       (ip_off),
        .ip_sel       (ip_sel),
        .dp_off       (dp_off),
        .dp_sel       (dp_sel),
        .simd_csr     (simd_csr),
        .simd_csr_mask(simd_csr_mask),
        .stk_regs     (stk_regs),
        .vec_regs     (vec_regs),
        .line         (wr_data)
    );

    assign wr_be = '1;
endmodule

// File: rtl/fpctx_image_writer_chk.sv
module fpctx_image_writer_chk
    import fpctx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [ADDR_W-1:0]     base_addr,
    input logic                  wr_valid,
    input logic                  wr_ready,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [LINE_BYTES-1:0] wr_be,
    input logic                  done,
    input logic                  fault
);
    logic [IDX_W:0] beats_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (done) begin
            beats_q <= '0;
        end else if (wr_valid && wr_ready) begin
            beats_q <= beats_q + 1'b1;
        end
    end

    // R1
    a_r1_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wr_valid);
    a_r1_misaligned_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wr_valid && base_addr[OFF_W-1:0] != '0) |=> (fault && !wr_valid));
    // R2
    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[OFF_W-1:0] == '0));
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || wr_addr == $past(wr_addr) + ADDR_W'(LINE_BYTES)));
    // R3
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));
    // R10
    a_r10_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_valid && wr_ready));
    a_r10_line_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (beats_q == (IDX_W+1)'(LN_LAST + 1)));
    // R11
    a_r11_full_be: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (&wr_be));
endmodule

bind fpctx_image_writer fpctx_image_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .base_addr(base_addr),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .done     (done),
    .fault    (fault)
);

// File: tb/fpctx_image_writer_tb.sv
module fpctx_image_writer_tb;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   base_addr = '0;
    logic          long_mode = 1'b0, ptr64_fmt = 1'b0, addr16_mode = 1'b0;
    logic [15:0]   ctrl_word = '0, stat_word = '0, tag_word = '0, last_opc = '0;
    logic [63:0]   ip_off = '0, dp_off = '0;
    logic [15:0]   ip_sel = '0, dp_sel = '0;
    logic [31:0]   simd_csr = '0, simd_csr_mask = '0;
    logic [639:0]  stk_regs = '0;
    logic [2047:0] vec_regs = '0;
    logic          wr_valid, wr_ready = 1'b0;
    logic [31:0]   wr_addr;
    logic [127:0]  wr_data;
    logic [15:0]   wr_be;
    logic          done, fault;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fpctx_image_writer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .long_mode(long_mode), .ptr64_fmt(ptr64_fmt), .addr16_mode(addr16_mode),
        .ctrl_word(ctrl_word), .stat_word(stat_word), .tag_word(tag_word),
        .last_opc(last_opc), .ip_off(ip_off), .ip_sel(ip_sel), .dp_off(dp_off),
        .dp_sel(dp_sel), .simd_csr(simd_csr), .simd_csr_mask(simd_csr_mask),
        .stk_regs(stk_regs), .vec_regs(vec_regs), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .done(done), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input int s);
        ctrl_word     = 16'h0300 + 16'(s);
        stat_word     = 16'h4000 ^ 16'(s * 17);
        tag_word      = 16'(s * 40503) ^ 16'h5A3C;
        last_opc      = 16'hF800 | 16'(s * 13);
        ip_off        = 64'hFEDC_BA98_7654_3210 + 64'(s);
        dp_off        = 64'h8877_6655_4433_2211 ^ 64'(s * 257);
        ip_sel        = 16'h1B00 + 16'(s);
        dp_sel        = 16'h2300 + 16'(s);
        simd_csr      = 32'h0000_1F80 + 32'(s);
        simd_csr_mask = 32'h0000_FFFF - 32'(s);
        for (int k = 0; k < 8; k++)
            stk_regs[k*80 +: 80] = {16'h8000 | 16'(s * 3 + k), 64'h0123_4567_89AB_CDEF ^ {8{8'(s + k)}}};
        for (int k = 0; k < 16; k++)
            vec_regs[k*128 +: 128] = {4{32'(k) * 32'h0101_0101 + 32'(s)}};
    endtask

    function automatic logic [7:0] exp_tag();
        logic [7:0] t;
        for (int i = 0; i < 8; i++) t[i] = (tag_word[2*i +: 2] != 2'b11);
        return t;
    endfunction

    function automatic logic [127:0] exp_line(input int n);
        logic [63:0] ip, dp;
        logic [15:0] op;
        ip = addr16_mode ? {48'h0, ip_off[15:0]} : ip_off;
        dp = addr16_mode ? {48'h0, dp_off[15:0]} : dp_off;
        op = {5'b0, last_opc[10:0]};
        if (n == 0)
            return ptr64_fmt ? {ip, op, 8'h00, exp_tag(), stat_word, ctrl_word}
                             : {16'h0, ip_sel, ip[31:0], op, 8'h00, exp_tag(), stat_word, ctrl_word};
        if (n == 1)
            return ptr64_fmt ? {simd_csr_mask, simd_csr, dp}
                             : {simd_csr_mask, simd_csr, 16'h0, dp_sel, dp[31:0]};
        if (n >= 2 && n <= 9) return {48'h0, stk_regs[(n-2)*80 +: 80]};
        if (n >= 10 && n <= 17) return vec_regs[(n-10)*128 +: 128];
        if (n >= 18 && n <= 25) return long_mode ? vec_regs[(n-10)*128 +: 128] : 128'h0;
        return 128'h0;
    endfunction

    // Called at a negedge; returns at the negedge where done is seen.
    task automatic run_img(input logic [31:0] b, input int s, input bit m64,
                           input bit w64, input bit a16, input int stall, input bit poke);
        int n;
        bit rdy;
        bit seen_done;
        string rq;
        fill(s);
        long_mode = m64; ptr64_fmt = w64; addr16_mode = a16;
        base_addr = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_addr = 32'hDEAD_BEE3;
        n = 0;
        seen_done = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (done) begin
                chk(n == 29 && !wr_valid, "R10 done after last line", 128'(n), 128'd29);
                seen_done = 1'b1;
                break;
            end
            start = 1'b0;
            if (poke && c == 6) begin
                start = 1'b1;
                base_addr = 32'h0000_0105;
            end
            rdy = (stall == 0) ? 1'b1 : (((c * 7 + s) % stall) != 0);
            wr_ready = rdy;
            chk(!fault, "R10 start while busy ignored", 128'(fault), 128'd0);
            if (wr_valid) begin
                chk(wr_addr == b + 32'(16 * n) && n < 29, "R2 address", 128'(wr_addr), 128'(b + 32'(16 * n)));
                chk(&wr_be, "R11 byte enables", 128'(wr_be), 128'hFFFF);
                rq = (n < 2) ? (w64 ? "R5 header line" : "R4 header line")
                   : (n < 10) ? "R8 stack line" : "R9 vector line";
                chk(wr_data == exp_line(n), rq, wr_data, exp_line(n));
                if (n == 0) begin
                    chk(wr_data[39:32] == exp_tag(), "R6 abridged tag", 128'(wr_data[39:32]), 128'(exp_tag()));
                    chk(wr_data[63:59] == 5'b0, "R7 opcode top bits", 128'(wr_data[63:59]), 128'd0);
                    if (a16)
                        chk(wr_data[127:80] == 48'h0 || (!w64 && wr_data[95:80] == 16'h0),
                            "R7 short pointer", wr_data, exp_line(0));
                end
                // R3: a stalled line is re-checked next cycle at the same n
                if (rdy) n++;
            end else begin
                chk(1'b0, "R2 valid dropped early", 128'(n), 128'd29);
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (!seen_done) chk(1'b0, "R10 no done pulse", 128'(n), 128'd29);
    endtask

    task automatic run_bad(input logic [31:0] b);
        base_addr = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(fault && !wr_valid, "R1 fault pulse", {fault, wr_valid}, 128'b10);
        @(negedge clk);
        chk(!fault && !wr_valid, "R1 fault single, no write", {fault, wr_valid}, 128'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!wr_valid && !done && !fault, "R2 reset state", {wr_valid, done, fault}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 8; m++)
            run_img(32'h0001_0000 + 32'(m * 1024), m + 1, m[0], m[1], m[2], 3 + (m % 3), 1'b0);
        for (int s = 20; s < 28; s++)
            run_img(32'h0008_0000 + 32'(s * 512), s, s[0], s[1], 1'b0, 0, 1'b0);
        run_img(32'h0000_4000, 40, 1'b1, 1'b0, 1'b0, 2, 1'b1);
        @(negedge clk);
        for (int lo = 1; lo < 16; lo++) run_bad(32'h0002_0000 + 32'(lo));
        run_img(32'h0000_0000, 41, 1'b0, 1'b0, 1'b1, 4, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule